// File: doc/BRIEF.md
# System Control Register Block

This block is a bank of general-purpose 32-bit registers reached over a simple single-cycle word bus, together with one command location. It sits in a 4 KiB byte window. The low 512 words are storage, and a few of them come out of reset holding fixed identification values. Software uses it for scratch and board configuration words. It also writes a code to the command location to ask the system for a reset or a power-off.

A request is one cycle in which `busValid` is high. `busWrite` selects a write, and the byte address selects the word (address bits [11:2]). Read data appears on `busRdata` in the cycle after the read request. Any access whose word index lies beyond the storage bank is dropped and reported by a one-cycle `busErr` pulse. The one exception is a write to the command location at byte offset 0xF00, which is decoded before the range check. A code of 1 or 2 produces a one-cycle `sysResetReq` pulse, a code of 3 produces a one-cycle `sysOffReq` pulse, and nothing is ever stored there.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, word 0x40 (byte 0x100) reads 0x05F20121, word 0x42 (byte 0x108) reads 0x05F30121, word 0x43 (byte 0x10C) reads 0x05F40121, and every other storage word reads zero.
- R2: A write with word index below 512 stores the full 32-bit data. A read of that index returns the stored word on `busRdata` in the cycle after the request.
- R3: `busRdata` is zero in every cycle that does not directly follow an in-range read request.
- R4: The word index is address bits [11:2]. Address bits [1:0] have no effect on which word is accessed.
- R5: A write of 1 or 2 to word index 0x3C0 (byte 0xF00) makes `sysResetReq` high for exactly the cycle after the request, with no `busErr`.
- R6: A write of 3 to word index 0x3C0 makes `sysOffReq` high for exactly the cycle after the request, with no `busErr`.
- R7: A write of any other value to word index 0x3C0 raises no request pulse and no `busErr`.
- R8: A read with word index 512 or above, or a write with word index 512 or above other than 0x3C0, raises `busErr` for the cycle after the request. It changes no storage word, and for a read `busRdata` is zero.
- R9: In a cycle after `busValid` was low, `busErr`, `sysResetReq` and `sysOffReq` are all low, and `sysResetReq` and `sysOffReq` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Request present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address inside the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| busErr | output | 1 | One-cycle pulse for a dropped access |
| sysResetReq | output | 1 | One-cycle system reset request |
| sysOffReq | output | 1 | One-cycle power-off request |

## Verification
A corrupted storage word stays hidden until that word is read, and then it shows on `busRdata` one cycle after the read. The bench therefore reads back every word it writes, the reset-default words, and a word whose index is an out-of-range alias of a written index. A wrong decode of the command or range shows up as a request or error pulse in the cycle after the request. The bench's model predicts all four outputs, and they are compared on every clock, so a stray or missing pulse is caught within one cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Strobes from control to datapath for the current request.
  typedef struct packed {
    logic storeEn;  // write the addressed storage word
    logic loadEn;   // capture the addressed word into read data
  } dpStrobe_t;

  // Reset value of a storage word.
  function automatic logic [31:0] resetWord(input int idx);
    case (idx)
      'h40:    return 32'h05F2_0121;
      'h42:    return 32'h05F3_0121;
      'h43:    return 32'h05F4_0121;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 512,
  parameter int unsigned CMD_IDX   = 'h3C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] wordIdx,
  output logic              errPulse,
  output logic              rstPulse,
  output logic              offPulse
);

  logic inRange;
  logic cmdWrite;
  logic wantRst;
  logic wantOff;
  logic wantErr;

  always_comb begin
    wordIdx  = busAddr >> 2;
    inRange  = (wordIdx < ADDR_W'(NUM_WORDS));
    cmdWrite = busValid && busWrite && (wordIdx == ADDR_W'(CMD_IDX));
    wantRst  = cmdWrite && ((busWdata == DATA_W'(1)) || (busWdata == DATA_W'(2)));
    wantOff  = cmdWrite && (busWdata == DATA_W'(3));
    wantErr  = busValid && !inRange && !cmdWrite;
    strobe.storeEn = busValid && busWrite && inRange;
    strobe.loadEn  = busValid && !busWrite && inRange;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      errPulse <= 1'b0;
      rstPulse <= 1'b0;
      offPulse <= 1'b0;
    end else begin
      errPulse <= wantErr;
      rstPulse <= wantRst;
      offPulse <= wantOff;
    end
  end

endmodule

// File: rtl/sysctl_datapath.sv
module sysctl_datapath
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wordIdx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned SIDX_W = $clog2(NUM_WORDS);

  logic [DATA_W-1:0] words [NUM_WORDS];

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    localparam logic [DATA_W-1:0] INIT = DATA_W'(resetWord(gi));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[gi] <= INIT;
      end else if (strobe.storeEn && (wordIdx == ADDR_W'(gi))) begin
        words[gi] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (strobe.loadEn) begin
      rdata <= words[wordIdx[SIDX_W-1:0]];
    end else begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 512,
  parameter int unsigned CMD_IDX   = 'h3C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic              sysResetReq,
  output logic              sysOffReq
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] wordIdx;

  sysctl_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .CMD_IDX(CMD_IDX)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata),
    .strobe(strobe), .wordIdx(wordIdx),
    .errPulse(busErr), .rstPulse(sysResetReq), .offPulse(sysOffReq)
  );

  sysctl_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)
  ) dp_i (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .wordIdx(wordIdx),
    .wdata(busWdata), .rdata(busRdata)
  );

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 512,
  parameter int unsigned CMD_IDX   = 'h3C0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              busErr,
  input logic              sysResetReq,
  input logic              sysOffReq
);

  logic [ADDR_W-1:0] idx;
  logic isCmdWr;
  logic oorAcc;
  assign idx     = busAddr >> 2;
  assign isCmdWr = busValid && busWrite && (idx == ADDR_W'(CMD_IDX));
  assign oorAcc  = busValid && (idx >= ADDR_W'(NUM_WORDS)) && !isCmdWr;

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sysResetReq |-> $past(isCmdWr && (busWdata == DATA_W'(1) || busWdata == DATA_W'(2)))); // R5

  AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sysOffReq |-> $past(isCmdWr && busWdata == DATA_W'(3))); // R6

  AST_CMD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    isCmdWr |=> !busErr); // R7

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    busErr |-> $past(oorAcc)); // R8

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (oorAcc && !busWrite) |=> (busErr && busRdata == '0)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busValid |=> (!busErr && !sysResetReq && !sysOffReq && busRdata == '0)); // R9

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sysResetReq && sysOffReq)); // R9

endmodule

bind sysctl_regs sysctl_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .CMD_IDX(CMD_IDX)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata),
  .busRdata(busRdata), .busErr(busErr),
  .sysResetReq(sysResetReq), .sysOffReq(sysOffReq)
);

// File: tb/sysctl_regs_tb_top.sv
module sysctl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic        sysResetReq;
  logic        sysOffReq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  sysctl_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr),
    .sysResetReq(sysResetReq), .sysOffReq(sysOffReq)
  );

  // Behavioural reference model, updated at each rising edge.
  int unsigned model [512];
  int unsigned expRdata = 0;
  bit expErr = 0, expRst = 0, expOff = 0;
  bit modelLive = 0;

  always @(posedge clk) begin
    int widx;
    widx = int'(busAddr) / 4;
    if (!rst_n) begin
      for (int k = 0; k < 512; k++) model[k] = 0;
      model['h40] = 32'h05F20121;
      model['h42] = 32'h05F30121;
      model['h43] = 32'h05F40121;
      expRdata = 0; expErr = 0; expRst = 0; expOff = 0;
    end else begin
      expRdata = 0; expErr = 0; expRst = 0; expOff = 0;
      if (busValid) begin
        if (busWrite && widx == 'h3C0) begin
          expRst = (busWdata == 1) || (busWdata == 2);
          expOff = (busWdata == 3);
        end else if (widx >= 512) begin
          expErr = 1;
        end else if (busWrite) begin
          model[widx] = busWdata;
        end else begin
          expRdata = model[widx];
        end
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare all outputs against the model on every falling edge.
  always @(negedge clk) begin
    if (modelLive && !done) begin
      check("R2 rdata vs model", busRdata, expRdata);
      check("R8 busErr vs model", busErr, expErr);
      check("R5 sysResetReq vs model", sysResetReq, expRst);
      check("R6 sysOffReq vs model", sysOffReq, expOff);
    end
  end

  // One request; returns at the falling edge where its result is visible.
  task automatic op(input bit wr, input logic [11:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = wr; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic readExpect(input string tag, input logic [11:0] a, input logic [31:0] exp);
    op(1'b0, a, '0);
    check(tag, busRdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1;
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state of the outputs.
    check("R9 reset busErr", busErr, 0);
    check("R9 reset sysResetReq", sysResetReq, 0);
    check("R3 reset rdata", busRdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    modelLive = 1;

    // R1 reset defaults
    readExpect("R1 word 0x40", 12'h100, 32'h05F20121);
    readExpect("R1 word 0x41", 12'h104, 32'h0);
    readExpect("R1 word 0x42", 12'h108, 32'h05F30121);
    readExpect("R1 word 0x43", 12'h10C, 32'h05F40121);
    readExpect("R1 word 0", 12'h000, 32'h0);
    readExpect("R1 word 511", 12'h7FC, 32'h0);

    // R2 write/read patterns, including last word and a default word
    op(1'b1, 12'h000, 32'hDEADBEEF);
    op(1'b1, 12'h7FC, 32'hA5A5_5A5A);
    op(1'b1, 12'h100, 32'hFFFF_FFFF);
    readExpect("R2 word 0", 12'h000, 32'hDEADBEEF);
    readExpect("R2 word 511", 12'h7FC, 32'hA5A5_5A5A);
    readExpect("R2 word 0x40 overwritten", 12'h100, 32'hFFFF_FFFF);
    idle(1);
    check("R3 rdata zero after idle", busRdata, 0);

    // R4 low address bits ignored
    op(1'b1, 12'h013, 32'h1234_5678);
    readExpect("R4 word 4 via aligned address", 12'h010, 32'h1234_5678);
    readExpect("R4 word 4 via offset 1", 12'h011, 32'h1234_5678);

    // R5 reset codes
    op(1'b1, 12'hF00, 32'd1);
    check("R5 code 1 pulse", sysResetReq, 1);
    check("R5 code 1 no err", busErr, 0);
    @(negedge clk);
    check("R5 pulse one cycle", sysResetReq, 0);
    op(1'b1, 12'hF00, 32'd2);
    check("R5 code 2 pulse", sysResetReq, 1);

    // R6 power-off code
    op(1'b1, 12'hF00, 32'd3);
    check("R6 code 3 pulse", sysOffReq, 1);
    check("R6 code 3 no reset", sysResetReq, 0);

    // R7 other codes: nothing
    op(1'b1, 12'hF00, 32'd0);
    check("R7 code 0 no reset", sysResetReq, 0);
    check("R7 code 0 no err", busErr, 0);
    op(1'b1, 12'hF02, 32'd4);
    check("R7 code 4 no off", sysOffReq, 0);
    check("R7 code 4 no err", busErr, 0);

    // R8 out-of-range accesses
    op(1'b1, 12'h800, 32'hCAFE_F00D);
    check("R8 oor write err", busErr, 1);
    readExpect("R8 oor write left word 0", 12'h000, 32'hDEADBEEF);
    op(1'b0, 12'h9FC, '0);
    check("R8 oor read err", busErr, 1);
    check("R8 oor read zero", busRdata, 0);
    op(1'b0, 12'hF00, '0);
    check("R8 command read err", busErr, 1);
    @(negedge clk);
    check("R9 err one cycle", busErr, 0);

    // back-to-back mix
    op(1'b1, 12'h200, 32'h0000_0042);
    op(1'b0, 12'h200, '0);
    op(1'b1, 12'hFFC, 32'h1);
    op(1'b0, 12'h104, '0);
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule